// File: doc/BRIEF.md
# Packed high-word multiply-accumulate unit

This datapath unit works on packed signed 32-bit words. For each active lane it forms the full signed 64-bit product of two source lanes and keeps only the upper word. The unit can return that word as it is. It can also add it to the matching lane of a third operand, or subtract it from that lane, with clamping to the signed 32-bit range. A fourth operation returns the doubled product's upper word, with saturation. Every operation has a rounding variant that rounds from the highest discarded product bit.

A lane-mode input selects how wide the operation is. In narrow mode only lane 0 is computed and its result is sign-extended across the 64-bit output. In wide mode two lanes are computed independently. The result is registered and appears one cycle after the input strobe. Clamping events collect in a sticky overflow flag until a dedicated clear input resets it.

Top module: `mswmac_top`

## Requirements
- R1: With `op` = 0 (high-word multiply), each active lane result is bits 63:32 of the signed 64-bit product of the `src_a` and `src_b` lanes. Lane i occupies bits 32i+31:32i. This operation never sets the overflow flag.
- R2: With `rnd` = 1, operations 0, 1 and 2 use a rounded high word instead of the plain one. The rounded high word is bits 32:1 of (product bits 63:31, a 33-bit value) + 1.
- R3: With `op` = 1 (accumulate), the lane result is the `src_c` lane plus the high word, clamped to the range -2^31 .. 2^31-1.
- R4: With `op` = 2 (subtract), the lane result is the `src_c` lane minus the high word, clamped to the same range.
- R5: Any clamp performed by accumulate or subtract in an active lane sets the overflow flag.
- R6: With `op` = 3 (doubling multiply), the lane result is product bits 62:31. With `rnd` = 1 it is instead bits 32:1 of (product bits 63:30, a 34-bit value) + 1.
- R7: In the doubling multiply, when both lane operands equal 0x80000000, the lane result is 0x7FFFFFFF and the overflow flag is set.
- R8: With `wide` = 0, only lane 0 is computed and `result[63:32]` is the sign extension of `result[31:0]`. The upper operand lanes then have no effect, on the result or on the flag.
- R9: With `wide` = 1, lanes 0 and 1 are computed independently of each other.
- R10: `out_valid` is high exactly one cycle after `in_valid`. `result` loads the new value in that same cycle and holds it while `in_valid` is low.
- R11: The overflow flag stays set until `ovf_clr` is high for a cycle, which clears it. An overflow that arrives in the same cycle as a clear leaves the flag set. The flag changes in the same cycle that the result appears.
- R12: While `rst` is high at a clock edge, the unit resets: `result` is 0, `out_valid` is 0 and `ovf_flag` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| op | input | 2 | 0 high-word multiply, 1 accumulate, 2 subtract, 3 doubling multiply |
| rnd | input | 1 | Rounding variant select |
| wide | input | 1 | 0: lane 0 only, 1: two lanes |
| src_a | input | 64 | First multiplicand, packed lanes |
| src_b | input | 64 | Second multiplicand, packed lanes |
| src_c | input | 64 | Accumulate/subtract base, packed lanes |
| ovf_clr | input | 1 | Clears the sticky overflow flag |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| result | output | 64 | Registered packed result |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
Every result, the valid strobe and the overflow flag are due on the first rising edge after the inputs are applied. The reference model updates its expected state on that same edge from the inputs it sampled. The bench drives inputs on falling edges and compares all three outputs against the model on the next falling edge, every cycle. Because of this, a one-cycle slip, a lost hold, or a flag that changes too early or too late shows up as a mismatch at once. The vectors cover clamping at both limits, the 0x80000000 squared case with and without rounding, and the effect of narrow mode on the upper lanes. They also include a clear that coincides with a new overflow.

// File: rtl/mswmac_pkg.sv
package mswmac_pkg;
  typedef enum logic [1:0] {
    OP_HIMUL = 2'd0,
    OP_ACC   = 2'd1,
    OP_SUB   = 2'd2,
    OP_DBL   = 2'd3
  } mac_op_e;
endpackage

// File: rtl/mswmac_addsat.sv
module mswmac_addsat #(
  parameter int W = 32
) (
  input  logic [W-1:0] base,
  input  logic [W-1:0] term,
  input  logic         do_sub,
  output logic [W-1:0] y,
  output logic         clip
);
  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

  logic [W:0] ext;

  always_comb begin
    if (do_sub) ext = {base[W-1], base} - {term[W-1], term};
    else        ext = {base[W-1], base} + {term[W-1], term};
    clip = ext[W] ^ ext[W-1];
    if (clip) y = ext[W] ? SMIN : SMAX;
    else      y = ext[W-1:0];
  end

  always_comb begin
    if (clip === 1'b1)
      AST_CLIP_AT_LIMIT: assert (y == SMAX || y == SMIN); // R3
  end
endmodule

// File: rtl/mswmac_lane.sv
module mswmac_lane
  import mswmac_pkg::*;
#(
  parameter int W = 32
) (
  input  mac_op_e      op,
  input  logic         rnd,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] y,
  output logic         ovf
);
  localparam int PW = 2 * W;
  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

  logic signed [PW-1:0] prod;
  logic [W:0]           hi_sum;
  logic [W+1:0]         dbl_sum;
  logic [W-1:0]         hi_word;
  logic [W-1:0]         dbl_word;
  logic                 both_min;
  logic [W-1:0]         sat_y;
  logic                 sat_clip;

  assign prod     = $signed(a) * $signed(b);
  assign hi_sum   = prod[PW-1:W-1] + {{W{1'b0}}, 1'b1};
  assign dbl_sum  = prod[PW-1:W-2] + {{(W+1){1'b0}}, 1'b1};
  assign hi_word  = rnd ? hi_sum[W:1] : prod[PW-1:W];
  assign dbl_word = rnd ? dbl_sum[W:1] : prod[PW-2:W-1];
  assign both_min = (a == SMIN) && (b == SMIN);

  mswmac_addsat #(.W(W)) u_sat (
    .base   (c),
    .term   (hi_word),
    .do_sub (op == OP_SUB),
    .y      (sat_y),
    .clip   (sat_clip)
  );

  always_comb begin
    y   = hi_word;
    ovf = 1'b0;
    unique case (op)
      OP_HIMUL: begin
        y   = hi_word;
        ovf = 1'b0;
      end
      OP_ACC, OP_SUB: begin
        y   = sat_y;
        ovf = sat_clip;
      end
      OP_DBL: begin
        y   = both_min ? SMAX : dbl_word;
        ovf = both_min;
      end
      default: ;
    endcase
  end

  always_comb begin
    if (op === OP_DBL && a === SMIN && b === SMIN)
      AST_DBL_MIN_SQUARED: assert (y == SMAX && ovf); // R7
    if (op === OP_HIMUL)
      AST_HIMUL_NO_LANE_OVF: assert (!ovf); // R1
  end
endmodule

// File: rtl/mswmac_sticky.sv
module mswmac_sticky (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst) flag <= 1'b0;
    else     flag <= (flag & ~clr) | set;
  end

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
    flag && !clr |=> flag); // R11
  AST_STICKY_CLEAR: assert property (@(posedge clk) disable iff (rst)
    clr && !set |=> !flag); // R11
  AST_STICKY_SET: assert property (@(posedge clk) disable iff (rst)
    set |=> flag); // R5
endmodule

// File: rtl/mswmac_top.sv
module mswmac_top
  import mswmac_pkg::*;
#(
  parameter int LANE_W = 32,
  parameter int LANES  = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic [1:0]               op,
  input  logic                     rnd,
  input  logic                     wide,
  input  logic [LANE_W*LANES-1:0]  src_a,
  input  logic [LANE_W*LANES-1:0]  src_b,
  input  logic [LANE_W*LANES-1:0]  src_c,
  input  logic                     ovf_clr,
  output logic                     out_valid,
  output logic [LANE_W*LANES-1:0]  result,
  output logic                     ovf_flag
);
  localparam int DW = LANE_W * LANES;

  mac_op_e            op_e;
  logic [DW-1:0]      nxt;
  logic [LANES-1:0]   lane_ovf;
  logic [LANES-1:0]   lane_on;
  logic               any_ovf;

  assign op_e = mac_op_e'(op);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] ly;
    logic              lo;

    mswmac_lane #(.W(LANE_W)) u_lane (
      .op  (op_e),
      .rnd (rnd),
      .a   (src_a[i*LANE_W +: LANE_W]),
      .b   (src_b[i*LANE_W +: LANE_W]),
      .c   (src_c[i*LANE_W +: LANE_W]),
      .y   (ly),
      .ovf (lo)
    );

    if (i == 0) begin : g_base
      assign lane_on[i]        = 1'b1;
      assign nxt[LANE_W-1:0]   = ly;
    end else begin : g_upper
      assign lane_on[i]               = wide;
      assign nxt[i*LANE_W +: LANE_W]  = wide ? ly : {LANE_W{nxt[LANE_W-1]}};
    end
    assign lane_ovf[i] = lo & lane_on[i];
  end

  assign any_ovf = in_valid & (|lane_ovf);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= nxt;
    end
  end

  mswmac_sticky u_flag (
    .clk  (clk),
    .rst  (rst),
    .set  (any_ovf),
    .clr  (ovf_clr),
    .flag (ovf_flag)
  );

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R10
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result) && !out_valid); // R10
  AST_NARROW_SIGN_EXT: assert property (@(posedge clk) disable iff (rst)
    in_valid && !wide |=> result[DW-1:LANE_W] == {(DW-LANE_W){result[LANE_W-1]}}); // R8
  AST_HIMUL_KEEPS_FLAG: assert property (@(posedge clk) disable iff (rst)
    in_valid && op == OP_HIMUL && !ovf_clr && !ovf_flag |=> !ovf_flag); // R1
endmodule

// File: tb/sim_mswmac_top.sv
module sim_mswmac_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  op = 2'd0;
  logic        rnd = 1'b0;
  logic        wide = 1'b0;
  logic [63:0] src_a = '0;
  logic [63:0] src_b = '0;
  logic [63:0] src_c = '0;
  logic        ovf_clr = 1'b0;
  logic        out_valid;
  logic [63:0] result;
  logic        ovf_flag;

  int compared = 0;
  int mismatched = 0;
  string cur_req = "R12";
  string e_req = "R12";
  logic [63:0] e_res = '0;
  logic        e_v = 1'b0;
  logic        e_f = 1'b0;
  bit          started = 0;
  int          cycles = 0;

  always #10 clk = ~clk;

  mswmac_top u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .rnd(rnd), .wide(wide),
    .src_a(src_a), .src_b(src_b), .src_c(src_c), .ovf_clr(ovf_clr),
    .out_valid(out_valid), .result(result), .ovf_flag(ovf_flag)
  );

  function automatic logic [31:0] clamp32(input longint v, output bit o);
    o = 1'b0;
    if (v > 64'sd2147483647) begin o = 1'b1; return 32'h7FFFFFFF; end
    if (v < -64'sd2147483648) begin o = 1'b1; return 32'h80000000; end
    return v[31:0];
  endfunction

  function automatic logic [31:0] lane_ref(input int opc, input bit r,
      input logic [31:0] a, input logic [31:0] b, input logic [31:0] c, output bit o);
    longint sa, sb, sc, p, hw, t;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    sc = longint'($signed(c));
    p  = sa * sb;
    o  = 1'b0;
    hw = r ? (((p >>> 31) + 1) >>> 1) : (p >>> 32);
    case (opc)
      0: return hw[31:0];
      1: begin t = sc + hw; return clamp32(t, o); end
      2: begin t = sc - hw; return clamp32(t, o); end
      default: begin
        if (a == 32'h80000000 && b == 32'h80000000) begin o = 1'b1; return 32'h7FFFFFFF; end
        t = r ? (((p >>> 30) + 1) >>> 1) : (p >>> 31);
        return t[31:0];
      end
    endcase
  endfunction

  always @(posedge clk) begin
    logic [31:0] y0, y1;
    bit o0, o1;
    started <= 1;
    cycles  <= cycles + 1;
    if (rst) begin
      e_res <= '0; e_v <= 1'b0; e_f <= 1'b0; e_req <= "R12";
    end else begin
      y0 = lane_ref(int'(op), rnd, src_a[31:0], src_b[31:0], src_c[31:0], o0);
      y1 = lane_ref(int'(op), rnd, src_a[63:32], src_b[63:32], src_c[63:32], o1);
      if (!wide) begin y1 = {32{y0[31]}}; o1 = 1'b0; end
      e_v   <= in_valid;
      e_f   <= (ovf_clr ? 1'b0 : e_f) | (in_valid & (o0 | o1));
      if (in_valid) e_res <= {y1, y0};
      e_req <= cur_req;
    end
  end

  always @(negedge clk) begin
    if (started) begin
      compared++;
      if (result !== e_res) begin
        mismatched++;
        $display("FAIL %s result actual=%h expected=%h", e_req, result, e_res);
      end
      compared++;
      if (out_valid !== e_v) begin
        mismatched++;
        $display("FAIL R10 out_valid actual=%b expected=%b", out_valid, e_v);
      end
      compared++;
      if (ovf_flag !== e_f) begin
        mismatched++;
        $display("FAIL R5/R11 (%s) ovf_flag actual=%b expected=%b", e_req, ovf_flag, e_f);
      end
    end
  end

  task automatic drive(input string req, input bit v, input int opc, input bit r, input bit w,
                       input logic [63:0] a, input logic [63:0] b, input logic [63:0] c,
                       input bit clr);
    @(negedge clk);
    cur_req = req; in_valid = v; op = opc[1:0]; rnd = r; wide = w;
    src_a = a; src_b = b; src_c = c; ovf_clr = clr;
  endtask

  task automatic idle(input string req);
    drive(req, 0, 0, 0, 0, '0, '0, '0, 0);
  endtask

  function automatic logic [31:0] pick();
    case ($urandom_range(0, 5))
      0: return 32'h80000000;
      1: return 32'h7FFFFFFF;
      2: return 32'hFFFFFFFF;
      3: return 32'h00000000;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle("R12");
    // R1: plain high word, both signs
    drive("R1", 1, 0, 0, 1, {32'hFFFF0000, 32'h40000000}, {32'h00030000, 32'h00000004}, '0, 0);
    // R2: rounding picks up the discarded bit 31
    drive("R2", 1, 0, 1, 1, {32'h00010000, 32'h00008000}, {32'h00008000, 32'h00010000}, '0, 0);
    // R3: accumulate clamps high
    drive("R3", 1, 1, 0, 1, {32'h7FFFFFFF, 32'h40000000}, {32'h7FFFFFFF, 32'h00000008}, {32'h7FFFFFF0, 32'h00000005}, 0);
    drive("R11", 0, 0, 0, 0, '0, '0, '0, 1);
    // R4: subtract clamps low
    drive("R4", 1, 2, 1, 1, {32'h00000001, 32'h7FFFFFFF}, {32'h00000001, 32'h7FFFFFFF}, {32'h12345678, 32'h80000010}, 0);
    // R11: clear coinciding with new overflow keeps flag set
    drive("R11", 1, 1, 0, 0, {32'h0, 32'h7FFFFFFF}, {32'h0, 32'h7FFFFFFF}, {32'h0, 32'h7FFFFFFF}, 1);
    drive("R11", 0, 0, 0, 0, '0, '0, '0, 1);
    // R6: doubling with and without rounding
    drive("R6", 1, 3, 0, 1, {32'hC0000000, 32'h40000000}, {32'h00000003, 32'h40000000}, '0, 0);
    drive("R6", 1, 3, 1, 1, {32'h00008001, 32'h00004001}, {32'h00008000, 32'h00004000}, '0, 0);
    // R7: most negative squared in both lanes, with rounding too
    drive("R7", 1, 3, 0, 1, {32'h80000000, 32'h80000000}, {32'h80000000, 32'h80000000}, '0, 0);
    drive("R7", 1, 3, 1, 0, {32'h0, 32'h80000000}, {32'h0, 32'h80000000}, '0, 1);
    drive("R11", 0, 0, 0, 0, '0, '0, '0, 1);
    // R8: narrow mode ignores upper lane that would overflow
    drive("R8", 1, 3, 0, 0, {32'h80000000, 32'hC0000000}, {32'h80000000, 32'h40000000}, '0, 0);
    drive("R8", 1, 1, 0, 0, {32'h7FFFFFFF, 32'h00000002}, {32'h7FFFFFFF, 32'h00000003}, {32'h7FFFFFFF, 32'hFFFFFFF0}, 0);
    // R9: lanes independent, one clamps and one does not
    drive("R9", 1, 2, 0, 1, {32'h00000010, 32'h80000000}, {32'h00000010, 32'h7FFFFFFF}, {32'h00000100, 32'h7FFFFF00}, 0);
    // R10: idle cycles must hold the result
    idle("R10"); idle("R10");
    drive("R11", 0, 0, 0, 0, '0, '0, '0, 1);
    // R12: mid-run reset
    drive("R12", 1, 1, 0, 1, {2{32'h7FFFFFFF}}, {2{32'h7FFFFFFF}}, {2{32'h7FFFFFFF}}, 0);
    rst = 1'b1;
    idle("R12");
    @(negedge clk); rst = 1'b0;
    for (int k = 0; k < 600; k++) begin
      int opc;
      opc = $urandom_range(0, 3);
      drive(opc == 0 ? "R1" : opc == 1 ? "R3" : opc == 2 ? "R4" : "R6",
            $urandom_range(0, 3) != 0, opc, $urandom_range(0, 1), $urandom_range(0, 1),
            {pick(), pick()}, {pick(), pick()}, {pick(), pick()}, $urandom_range(0, 7) == 0);
    end
    idle("R10"); idle("R10");
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  always @(negedge clk) begin
    if (cycles > 5000) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=%0d cycles expected=<5000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule